// File: doc/BRIEF.md
# Serial DAC Write Controller

This block runs on the host side of a link to a current-output multiplying DAC. It takes a 14-bit code through a valid/ready handshake and sends it over a three-wire serial link made of an active-low chip select, a serial clock and a serial data line. Each transfer is a 16-bit frame: two zero pad bits come first, then the code, most significant bit first. The receiver keeps only the last 14 bits it shifts in, so the pad bits fall off its shift register. When chip select returns high, the receiver copies the code into its holding register.

All interface timing is counted in system clock cycles, and parameters set each count. These counts are the serial clock high time, the serial clock low time, the chip-select hold after the last falling clock edge, and the idle gap before the next frame may begin. Chip select falls while the serial clock is low, and the first data bit is already on the line at that moment. The serial data line changes only on the cycle the serial clock falls. This gives a full low phase of setup time and a full high phase of hold time around every rising edge. All outputs come straight from registers.

Top module: `dac_serial_loader`

## Requirements
- R1: During and right after reset, chip select is high, the serial clock is low, ready is high and done is low.
- R2: Each accepted code produces exactly 16 rising serial clock edges while chip select is low. The bits sampled on those edges are two zeros followed by code bit 13 down to code bit 0.
- R3: The serial data line keeps its value while the serial clock is high, and also on the cycle the serial clock rises. It changes only on the cycle the clock falls or while the clock is low.
- R4: Every serial clock high phase lasts exactly HI_CYC system cycles. Every low phase between two rising edges, including the first one counted from the chip-select fall, lasts exactly LO_CYC cycles.
- R5: Chip select rises exactly CSH_CYC cycles after the last falling serial clock edge. The serial clock is never high while chip select is high.
- R6: done is high for exactly one cycle, the cycle on which chip select rises, and at no other time.
- R7: in_ready goes low on the cycle after a code is accepted. It stays low while chip select is low and for exactly GAP_CYC cycles after chip select rises. Valid or code changes during this busy period do not alter the frame being sent. With valid low, no frame starts.
- R8: After chip select rises, the receiver's holding register equals the accepted code. This holds for the boundary codes 0x0000 and 0x3FFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A code is offered |
| in_code | input | CODE_W | Code to load into the DAC |
| in_ready | output | 1 | Controller can accept a code |
| cs_n | output | 1 | Active-low chip select to the DAC |
| sclk | output | 1 | Serial clock; the DAC samples on its rising edge |
| sdo | output | 1 | Serial data to the DAC |
| done | output | 1 | One-cycle pulse on the cycle chip select rises |

## Verification
Directed codes come first, and each one exposes a different kind of fault. The all-zero and all-one codes show whether the pad bits stay zero and whether the frame is exactly 16 bits long. The alternating codes 0x2AAA and 0x1555 expose a shift that is off by one position. The single-bit codes 0x2000 and 0x0001 separate MSB-first order from LSB-first order. Random codes then follow, and some of them are sent with valid held high and a different code on the bus during the busy period, to show that the busy window is respected. A cycle monitor measures every clock phase, the chip-select hold, the done pulse and the idle gap against the parameter counts.

// File: rtl/dac_loader_pkg.sv
package dac_loader_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOW,
    ST_HIGH,
    ST_HOLD,
    ST_GAP
  } seq_state_e;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/dac_loader_timer.sv
module dac_loader_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);

endmodule

// File: rtl/dac_loader_shifter.sv
module dac_loader_shifter #(
  parameter int CODE_W  = 14,
  parameter int FRAME_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CODE_W-1:0] code,
  input  logic              shift,
  output logic              sdo,
  output logic              last_bit
);

  localparam int PAD_W = FRAME_W - CODE_W;
  localparam int BW    = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] frame_w;
  logic [FRAME_W-1:0] shreg;
  logic [BW-1:0]      bits_left;

  generate
    if (PAD_W > 0) begin : g_pad
      assign frame_w = {{PAD_W{1'b0}}, code};
    end else begin : g_nopad
      assign frame_w = code;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg     <= '0;
      bits_left <= '0;
    end else if (load) begin
      shreg     <= frame_w;
      bits_left <= BW'(FRAME_W);
    end else if (shift) begin
      shreg     <= {shreg[FRAME_W-2:0], 1'b0};
      bits_left <= bits_left - 1'b1;
    end
  end

  assign sdo      = shreg[FRAME_W-1];
  assign last_bit = (bits_left == BW'(1));

  // R2: the sequencer never advances past the final bit of a frame
  p_no_shift_past_last_r2: assert property (@(posedge clk) disable iff (rst)
    shift |-> (bits_left > BW'(1)));

endmodule

// File: rtl/dac_loader_seq.sv
module dac_loader_seq
  import dac_loader_pkg::*;
#(
  parameter int HI_CYC  = 2,
  parameter int LO_CYC  = 2,
  parameter int CSH_CYC = 2,
  parameter int GAP_CYC = 4,
  parameter int CNT_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic             last_bit,
  input  logic             tmr_expired,
  output logic             in_ready,
  output logic             cs_n,
  output logic             sclk,
  output logic             done,
  output logic             accept,
  output logic             shift,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val
);

  seq_state_e state;

  always_comb begin
    accept   = 1'b0;
    shift    = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state)
      ST_IDLE: if (in_valid && in_ready) begin
        accept   = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(LO_CYC - 1);
      end
      ST_LOW: if (tmr_expired) begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(HI_CYC - 1);
      end
      ST_HIGH: if (tmr_expired) begin
        tmr_load = 1'b1;
        if (last_bit) begin
          tmr_val = CNT_W'(CSH_CYC - 1);
        end else begin
          shift   = 1'b1;
          tmr_val = CNT_W'(LO_CYC - 1);
        end
      end
      ST_HOLD: if (tmr_expired) begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(GAP_CYC - 1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      in_ready <= 1'b1;
      cs_n     <= 1'b1;
      sclk     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (accept) begin
          state    <= ST_LOW;
          cs_n     <= 1'b0;
          in_ready <= 1'b0;
        end
        ST_LOW: if (tmr_expired) begin
          state <= ST_HIGH;
          sclk  <= 1'b1;
        end
        ST_HIGH: if (tmr_expired) begin
          sclk  <= 1'b0;
          state <= last_bit ? ST_HOLD : ST_LOW;
        end
        ST_HOLD: if (tmr_expired) begin
          cs_n  <= 1'b1;
          done  <= 1'b1;
          state <= ST_GAP;
        end
        ST_GAP: if (tmr_expired) begin
          in_ready <= 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Length of the current serial clock high phase, kept for checking only
  logic [CNT_W-1:0] hi_seen;
  always_ff @(posedge clk) begin
    if (rst)       hi_seen <= '0;
    else if (sclk) hi_seen <= hi_seen + 1'b1;
    else           hi_seen <= '0;
  end

  // R4: each high phase spans exactly HI_CYC cycles
  p_high_width_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk) |-> (hi_seen == CNT_W'(HI_CYC)));

  // R5: no clock activity outside a frame
  p_sclk_low_when_idle_r5: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  // R5: chip select releases only after the clock has been low
  p_cs_rise_after_low_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> !$past(sclk));

  // R6: done marks the chip-select rise and nothing else
  p_done_marks_rise_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> $rose(cs_n));

  p_rise_gives_done_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> done);

  // R7: no new code may be taken while a frame is on the wire
  p_busy_not_ready_r7: assert property (@(posedge clk) disable iff (rst)
    !cs_n |-> !in_ready);

endmodule

// File: rtl/dac_serial_loader.sv
module dac_serial_loader
  import dac_loader_pkg::*;
#(
  parameter int CODE_W  = 14,
  parameter int FRAME_W = 16,
  parameter int HI_CYC  = 2,
  parameter int LO_CYC  = 2,
  parameter int CSH_CYC = 2,
  parameter int GAP_CYC = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] in_code,
  output logic              in_ready,
  output logic              cs_n,
  output logic              sclk,
  output logic              sdo,
  output logic              done
);

  localparam int MAX_CYC = max4(HI_CYC, LO_CYC, CSH_CYC, GAP_CYC);
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             accept;
  logic             shift;
  logic             last_bit;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_expired;

  dac_loader_seq #(
    .HI_CYC (HI_CYC),
    .LO_CYC (LO_CYC),
    .CSH_CYC(CSH_CYC),
    .GAP_CYC(GAP_CYC),
    .CNT_W  (CNT_W)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .last_bit   (last_bit),
    .tmr_expired(tmr_expired),
    .in_ready   (in_ready),
    .cs_n       (cs_n),
    .sclk       (sclk),
    .done       (done),
    .accept     (accept),
    .shift      (shift),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val)
  );

  dac_loader_timer #(
    .CNT_W(CNT_W)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_expired)
  );

  dac_loader_shifter #(
    .CODE_W (CODE_W),
    .FRAME_W(FRAME_W)
  ) u_shift (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .code    (in_code),
    .shift   (shift),
    .sdo     (sdo),
    .last_bit(last_bit)
  );

  // R3: data is steady across the rising edge and the high phase
  p_sdo_stable_high_r3: assert property (@(posedge clk) disable iff (rst)
    (sclk && !cs_n) |-> $stable(sdo));

endmodule

// File: tb/dac_serial_loader_test.sv
`timescale 1ns/1ps
module dac_serial_loader_test;

  localparam int CW  = 14;
  localparam int FW  = 16;
  localparam int HI  = 2;
  localparam int LO  = 2;
  localparam int CSH = 2;
  localparam int GAP = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [CW-1:0] in_code = '0;
  logic          in_ready, cs_n, sclk, sdo, done;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  dac_serial_loader #(
    .CODE_W(CW), .FRAME_W(FW), .HI_CYC(HI), .LO_CYC(LO),
    .CSH_CYC(CSH), .GAP_CYC(GAP)
  ) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_code(in_code),
    .in_ready(in_ready), .cs_n(cs_n), .sclk(sclk), .sdo(sdo), .done(done)
  );

  // Behavioural receiver: shift on rising serial clock while selected, copy on select release
  logic [FW-1:0] rx_sreg = '0;
  logic [CW-1:0] rx_latched = '0;
  int            rx_edges = 0;

  always @(posedge sclk) if (!cs_n) begin
    rx_sreg  <= {rx_sreg[FW-2:0], sdo};
    rx_edges <= rx_edges + 1;
  end
  always @(posedge cs_n) rx_latched <= rx_sreg[CW-1:0];

  function automatic logic [FW-1:0] exp_frame(input logic [CW-1:0] c);
    return {{(FW-CW){1'b0}}, c};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Cycle monitor
  int bad_r3 = 0, bad_r4 = 0, bad_r5 = 0, bad_r6 = 0, bad_r7 = 0;
  logic p_sclk = 1'b0, p_cs = 1'b1, p_sdo = 1'b0;
  int run = 0, gap = 0;
  bit in_gap = 1'b0;

  always @(negedge clk) begin
    if (rst) begin
      p_sclk = 1'b0; p_cs = 1'b1; p_sdo = 1'b0; run = 0; gap = 0; in_gap = 1'b0;
    end else begin
      if (cs_n && sclk) bad_r5++;
      if (done !== (cs_n && !p_cs)) bad_r6++;
      if (!cs_n && in_ready) bad_r7++;
      if (!cs_n && p_cs) begin
        run = 1;
      end else if (!cs_n) begin
        if (sclk == p_sclk) run++;
        else begin
          if (p_sclk && run != HI) bad_r4++;
          if (!p_sclk && run != LO) bad_r4++;
          run = 1;
        end
      end else if (!p_cs) begin
        if (p_sclk || run != CSH) bad_r5++;
        in_gap = 1'b1;
        gap = 0;
      end
      if (in_gap) begin
        if (cs_n && !in_ready) gap++;
        else if (in_ready) begin
          if (gap != GAP) bad_r7++;
          in_gap = 1'b0;
        end
      end
      if (sclk && sdo !== p_sdo) bad_r3++;
      p_sclk = sclk; p_cs = cs_n; p_sdo = sdo;
    end
  end

  task automatic send(input logic [CW-1:0] code, input bit jam);
    int e0;
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_code  = code;
    e0 = rx_edges;
    @(negedge clk);
    chk("R7 ready drops after accept", 32'(in_ready), 32'd0);
    in_valid = jam;
    in_code  = ~code;
    while (!done) @(negedge clk);
    in_valid = 1'b0;
    chk("R8 latched code", 32'(rx_latched), 32'(code));
    chk("R2 frame bits", 32'(rx_sreg), 32'(exp_frame(code)));
    chk("R2 rising edges per frame", 32'(rx_edges - e0), 32'(FW));
    chk("R3 sdo changes", 32'(bad_r3), 32'd0);
    chk("R4 clock phase widths", 32'(bad_r4), 32'd0);
    chk("R5 select hold and idle clock", 32'(bad_r5), 32'd0);
    chk("R6 done pulse", 32'(bad_r6), 32'd0);
    chk("R7 busy window", 32'(bad_r7), 32'd0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int e0;
    void'($urandom(32'h5eed_0dac));
    repeat (3) @(negedge clk);
    chk("R1 cs_n in reset", 32'(cs_n), 32'd1);
    chk("R1 sclk in reset", 32'(sclk), 32'd0);
    chk("R1 ready in reset", 32'(in_ready), 32'd1);
    chk("R1 done in reset", 32'(done), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 cs_n after reset", 32'(cs_n), 32'd1);
    chk("R1 ready after reset", 32'(in_ready), 32'd1);

    // R7: no frame without valid
    e0 = rx_edges;
    repeat (40) @(negedge clk);
    chk("R7 idle with valid low cs_n", 32'(cs_n), 32'd1);
    chk("R7 idle with valid low edges", 32'(rx_edges - e0), 32'd0);

    // R8 boundary codes, R2 bit order patterns
    send(14'h0000, 1'b0);
    send(14'h3fff, 1'b1);
    send(14'h2aaa, 1'b0);
    send(14'h1555, 1'b1);
    send(14'h2000, 1'b0);
    send(14'h0001, 1'b1);
    send(14'h3fff, 1'b0);
    send(14'h0000, 1'b1);

    for (int i = 0; i < 40; i++) begin
      send(CW'($urandom), 1'($urandom));
    end

    // wait out the last gap so its length is measured
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    chk("R7 final gap", 32'(bad_r7), 32'd0);
    chk("R6 final done", 32'(bad_r6), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule